// File: doc/BRIEF.md
# Stereo Transmit Sample FIFO

This block buffers outgoing audio for a two-channel serial audio transmitter. Each of its eight entries holds one left/right sample pair. Software writes the left word and the right word through two separate write strobes. The left word waits in a staging register, and the pair enters the FIFO only when the right word arrives. A downstream serializer pulls one pair per request and receives the oldest pair on the next cycle.

The block drives a level-sensitive interrupt. One select input sets the FIFO level that raises it: either half empty (four or fewer pairs held) or completely empty. A sticky underflow flag also raises the interrupt. The flag is set when the serializer asks for data while the FIFO holds none. A status word carries the full flag at bit 12.

Dropping the FIFO enable flushes the stored pairs, the read and write positions, the staging register and the underflow flag. While the FIFO is disabled, writes are still accepted and read requests are ignored. Recovery software uses this: it disables the FIFO, stuffs it with silent pairs until it is full, and enables it again. Serialization then restarts cleanly on a pair boundary.

Top module: `stx_pair_fifo`

## Requirements
- R1: The FIFO holds up to DEPTH (8) pairs. Status bit 12 reads 1 exactly while eight pairs are held. All other status bits read 0.
- R2: A left write alone never adds an entry. A right write pushes the pair {most recently staged left word, right word}. If both strobes are active in the same cycle, the left word on the bus that cycle is used.
- R3: A right write while the FIFO is full is dropped. The stored contents and their order do not change.
- R4: A read request while the FIFO is enabled and not empty removes the oldest pair. That pair appears on the read outputs on the cycle after the request, and pairs leave in the order they were written.
- R5: A read request while the FIFO is enabled and empty drives zeros on both read outputs on the next cycle. It also sets the underflow flag, which stays set until the FIFO is disabled.
- R6: With level select 0, the level condition is true while four or fewer pairs are held. With level select 1, it is true only while zero pairs are held.
- R7: irq equals irq_en AND (level condition OR underflow flag). The output is combinational from the held state.
- R8: A 1-to-0 transition of fifo_en empties the FIFO, clears the staging word and clears the underflow flag. Writes in that same cycle are dropped. While disabled, writes fill the FIFO and read requests leave the read outputs unchanged.
- R9: After reset, the FIFO is empty, the read outputs and the status word are zero, and the underflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable; its falling edge flushes |
| lvl_sel | input | 1 | Interrupt level: 0 half empty, 1 empty |
| irq_en | input | 1 | Interrupt enable |
| wr_left | input | 1 | Left word write strobe |
| wr_left_data | input | DW | Left word |
| wr_right | input | 1 | Right word write strobe; commits the pair |
| wr_right_data | input | DW | Right word |
| rd_req | input | 1 | Serializer pair request |
| rd_left_data | output | DW | Left word of the served pair |
| rd_right_data | output | DW | Right word of the served pair |
| status | output | STS_W | Status word, full flag at bit 12 |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
Write, read and enable results land at the first clock edge after the stimulus. The full bit and irq reflect the new state right after that edge, and the read outputs carry the served pair from that edge on. The bench applies one stimulus per cycle and updates a behavioural queue model at the same edge. One time unit after the edge, it compares every output with the model. At chosen points it also checks hard-coded expected values for staging, drop-on-full, ordering, both level selects and flush.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic {
    LVL_HALF  = 1'b0,
    LVL_EMPTY = 1'b1
  } lvl_sel_e;
endpackage

// File: rtl/stx_stage.sv
module stx_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_left,
  input  logic [DW-1:0] wr_left_data,
  output logic [DW-1:0] pair_left
);
  logic [DW-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (flush)        stage_d = '0;
    else if (wr_left) stage_d = wr_left_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // a same-cycle left write takes part in the pair
  assign pair_left = wr_left ? wr_left_data : stage_q;
endmodule

// File: rtl/stx_store.sv
module stx_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  logic          wr_right,
  input  logic [DW-1:0] pair_left,
  input  logic [DW-1:0] pair_right,
  input  logic          rd_req,
  output logic [DW-1:0] rd_left,
  output logic [DW-1:0] rd_right,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int EW = 2 * DW;

  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] out_q, out_d;
  logic          push_ok, pop_ok, serve;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign serve   = en & rd_req & ~flush;
  assign push_ok = wr_right & ~full & ~flush;
  assign pop_ok  = serve & ~empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = bump(wptr_q);
      if (pop_ok)  rptr_d = bump(rptr_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
    out_d = empty ? '0 : mem_q[rptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (serve) out_q <= out_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic ld;
    assign ld = push_ok & (wptr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (ld) mem_q[i] <= {pair_left, pair_right};
    end
  end

  assign rd_left  = out_q[EW-1:DW];
  assign rd_right = out_q[DW-1:0];
  assign count    = cnt_q;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_left_only_no_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_right && !pop_ok && !flush) |=> $stable(cnt_q));
  p_full_drops_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ok && !flush) |=> (cnt_q == CW'(DEPTH)));
  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (serve && empty) |=> (rd_left == '0 && rd_right == '0));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_disabled_read_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rd_left) && $stable(rd_right)));
endmodule

// File: rtl/stx_irq.sv
module stx_irq
  import stx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rd_req,
  input  logic          empty,
  input  logic [CW-1:0] count,
  input  lvl_sel_e      lvl_sel,
  input  logic          irq_en,
  output logic          irq
);
  logic uf_q, uf_d, lvl_hit;

  always_comb begin
    uf_d = uf_q;
    if (!en)                uf_d = 1'b0;
    else if (rd_req & empty) uf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_q <= 1'b0;
    else        uf_q <= uf_d;
  end

  always_comb begin
    if (lvl_sel == LVL_EMPTY) lvl_hit = (count == '0);
    else                      lvl_hit = (count <= CW'(HALF));
  end

  assign irq = irq_en & (lvl_hit | uf_q);

  p_underflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && en) |=> uf_q);
  p_underflow_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_req && empty) |=> uf_q);
  p_disable_clears_uf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !uf_q);
endmodule

// File: rtl/stx_pair_fifo.sv
module stx_pair_fifo
  import stx_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 8,
  parameter int STS_W    = 16,
  parameter int FULL_BIT = 12,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             lvl_sel,
  input  logic             irq_en,
  input  logic             wr_left,
  input  logic [DW-1:0]    wr_left_data,
  input  logic             wr_right,
  input  logic [DW-1:0]    wr_right_data,
  input  logic             rd_req,
  output logic [DW-1:0]    rd_left_data,
  output logic [DW-1:0]    rd_right_data,
  output logic [STS_W-1:0] status,
  output logic             irq
);
  logic          en_q, flush, empty, full;
  logic [DW-1:0] pair_left;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush = en_q & ~fifo_en;

  stx_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_left(wr_left), .wr_left_data(wr_left_data), .pair_left(pair_left)
  );

  stx_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .en(fifo_en), .flush(flush),
    .wr_right(wr_right), .pair_left(pair_left), .pair_right(wr_right_data),
    .rd_req(rd_req), .rd_left(rd_left_data), .rd_right(rd_right_data),
    .count(count), .empty(empty), .full(full)
  );

  stx_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(fifo_en), .rd_req(rd_req),
    .empty(empty), .count(count), .lvl_sel(lvl_sel_e'(lvl_sel)),
    .irq_en(irq_en), .irq(irq)
  );

  always_comb begin
    status           = '0;
    status[FULL_BIT] = full;
  end

  p_full_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[FULL_BIT] |-> (count == CW'(DEPTH)));
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/stx_pair_fifo_tb.sv
module stx_pair_fifo_tb;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n, fifo_en, lvl_sel, irq_en, wr_left, wr_right, rd_req;
  logic [DW-1:0] wl_d, wr_d, rl, rr;
  logic [15:0] status;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2*DW-1:0] q[$];
  logic [DW-1:0] m_stage, m_l, m_r;
  logic m_uf, m_prev_en;

  always #2 clk = ~clk;

  stx_pair_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lvl_sel(lvl_sel),
    .irq_en(irq_en), .wr_left(wr_left), .wr_left_data(wl_d),
    .wr_right(wr_right), .wr_right_data(wr_d), .rd_req(rd_req),
    .rd_left_data(rl), .rd_right_data(rr), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [DW-1:0] st;
    if (!rst_n) begin
      q.delete(); m_stage = '0; m_l = '0; m_r = '0; m_uf = 0; m_prev_en = 0;
      return;
    end
    if (m_prev_en && !fifo_en) begin
      q.delete(); m_stage = '0; m_uf = 0;
    end else begin
      int sz = q.size();
      if (fifo_en && rd_req) begin
        if (sz > 0) {m_l, m_r} = q.pop_front();
        else begin m_l = '0; m_r = '0; m_uf = 1; end
      end
      st = wr_left ? wl_d : m_stage;
      if (wr_right && sz < DEPTH) q.push_back({st, wr_d});
      m_stage = st;
      if (!fifo_en) m_uf = 0;
    end
    m_prev_en = fifo_en;
  endtask

  task automatic compare();
    logic lvl;
    lvl = lvl_sel ? (q.size() == 0) : (q.size() <= DEPTH / 2);
    chk("R1 status", 64'(status), 64'(16'(q.size() == DEPTH) << 12));
    chk("R4 rd_left", 64'(rl), 64'(m_l));
    chk("R4 rd_right", 64'(rr), 64'(m_r));
    chk("R7 irq", 64'(irq), 64'(irq_en & (lvl | m_uf)));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    wr_left = 0; wr_right = 0; rd_req = 0;
  endtask

  task automatic put_pair(input logic [DW-1:0] l, input logic [DW-1:0] r);
    wr_left = 1; wl_d = l; wr_right = 1; wr_d = r; step();
  endtask

  task automatic pull();
    rd_req = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_en = 0; lvl_sel = 0; irq_en = 0;
    wr_left = 0; wr_right = 0; rd_req = 0; wl_d = '0; wr_d = '0;
    #1;
    step(); step();
    chk("R9 status", 64'(status), 64'h0);
    chk("R9 rd_left", 64'(rl), 64'h0);
    rst_n = 1; step();

    fifo_en = 1; irq_en = 1; step();
    chk("R6 half level at 0 pairs", 64'(irq), 64'h1);

    // R2 staging
    wr_left = 1; wl_d = 32'hA1; step();
    wr_left = 1; wl_d = 32'hA2; step();
    lvl_sel = 1; step();
    chk("R2 left alone adds nothing", 64'(irq), 64'h1);
    wr_right = 1; wr_d = 32'hB0; step();
    chk("R2 pair pushed", 64'(irq), 64'h0);
    pull();
    chk("R2 staged left", 64'(rl), 64'hA2);
    chk("R2 right", 64'(rr), 64'hB0);

    // R1/R3 fill then overfill
    lvl_sel = 0;
    for (int i = 0; i < DEPTH; i++) put_pair(32'h100 + i, 32'h200 + i);
    chk("R1 full bit", 64'(status), 64'h1000);
    put_pair(32'hDEAD, 32'hBEEF);
    chk("R3 still full", 64'(status), 64'h1000);

    // R4 ordering, R6 level
    for (int i = 0; i < DEPTH; i++) begin
      pull();
      chk("R4 order left", 64'(rl), 64'(32'h100 + i));
      chk("R4 order right", 64'(rr), 64'(32'h200 + i));
      if (i == 2) chk("R6 five held, half sel", 64'(irq), 64'h0);
      if (i == 3) begin
        chk("R6 four held, half sel", 64'(irq), 64'h1);
        lvl_sel = 1; step();
        chk("R6 four held, empty sel", 64'(irq), 64'h0);
        lvl_sel = 0;
      end
    end

    // R5 underflow, R3 dropped pair never appears
    pull();
    chk("R5 zero left", 64'(rl), 64'h0);
    chk("R3 dropped pair absent", 64'(rr), 64'h0);
    put_pair(32'h11, 32'h22); put_pair(32'h33, 32'h44);
    lvl_sel = 1; step();
    chk("R5 sticky underflow irq", 64'(irq), 64'h1);
    irq_en = 0; step();
    chk("R7 gated", 64'(irq), 64'h0);
    irq_en = 1;

    // R8 flush and refill while disabled
    wr_left = 1; wl_d = 32'h77;
    fifo_en = 0; put_pair(32'h55, 32'h66);
    chk("R8 flushed", 64'(status), 64'h0);
    wr_right = 1; wr_d = 32'h0; step();
    for (int i = 1; i < DEPTH; i++) put_pair(32'h0, 32'h0);
    chk("R8 refilled while disabled", 64'(status), 64'h1000);
    pull();
    chk("R8 read ignored", 64'(rl), 64'h0);
    chk("R8 read ignored full", 64'(status), 64'h1000);
    fifo_en = 1; step();
    chk("R8 underflow cleared", 64'(irq), 64'h0);
    pull();
    chk("R8 staging cleared", 64'(rl), 64'h0);
    chk("R8 zero pair", 64'(rr), 64'h0);
    for (int i = 0; i < 10; i++) begin
      rd_req = (i % 2 == 0); wr_left = (i % 3 == 0); wl_d = 32'h900 + i;
      wr_right = (i % 2 == 1); wr_d = 32'hA00 + i; lvl_sel = i[0];
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule